// File: doc/BRIEF.md
# SDIO Card Buffer Flush and CRC-Busy Controller

This block holds the control logic of a card-side SDIO data function. It turns firmware commands and link events into single-cycle flush pulses for the receive and transmit buffers. It also holds the host in busy after a data CRC error until firmware re-enables the function.

A local register port writes three targets, chosen by a 2-bit select:
- Select 0 is the flush command. It is write-only: bit 0 requests an RX flush and bit 1 requests a TX flush.
- Select 1 is the 4-bit control word.
- Select 2 is the status clear word, where a 1 in bit 12 clears the CRC-error flag.

The link side delivers three one-cycle strobes: a data CRC error, a packet ACK and a packet NACK. ACK and NACK both end a read retry. The CRC computation, the bus protocol and the FIFOs are outside the block.

Control word bits:
- Bit 0 enables the function.
- Bit 1 arms busy-on-CRC-error.
- Bit 2 enables TX auto-flush on ACK or NACK.
- Bit 3 selects how the host interrupt is synchronized. The block stores this bit and presents it on `ctrl_o` for the logic that uses it.

Top module: `sdio_flush_crc_ctrl`

## Requirements
- R1: A write to select 0 with bit 0 set makes `rx_flush_o` high for exactly the next cycle. The same write with bit 1 set does the same for `tx_flush_o`. Both bits together flush both buffers.
- R2: After reset `ctrl_o` is 4'h7, so bit 3 is 0. After reset `busy_o`, `crc_irq_o` and both flush outputs are 0.
- R3: A `crc_err_i` strobe clears control bit 0 in the next cycle, as seen on `ctrl_o[0]`.
- R4: A `crc_err_i` strobe raises `busy_o` in the next cycle only when control bits 1 and 0 were both set in the cycle of the strobe. Otherwise `busy_o` is unchanged.
- R5: Once raised, `busy_o` stays high until a write to select 1 with bit 0 set. It then falls in the cycle after that write.
- R6: With control bit 2 set, an `ack_i` or `nack_i` strobe makes `tx_flush_o` high for exactly the next cycle.
- R7: With control bit 2 clear, `ack_i` and `nack_i` produce no TX flush. A TX flush then comes only from a select 0 write with bit 1 set.
- R8: An automatic TX flush and a firmware TX flush in the same cycle produce one single-cycle pulse.
- R9: If `crc_err_i` and a control write with bit 0 set occur in the same cycle, control bit 0 ends up 0 and `busy_o` is not released. The other written control bits take effect.
- R10: `crc_err_i` sets `crc_irq_o` in the next cycle. The flag then holds until a write to select 2 with bit 12 set. A write to select 2 with bit 12 clear does not clear it. A new error in the same cycle as a clear leaves the flag set.
- R11: Control bit 3 is stored as written and is presented on `ctrl_o[3]`. It has no effect on flushing or busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Write target: 0 flush command, 1 control, 2 status clear |
| reg_wdata_i | input | DATA_W | Write data |
| crc_err_i | input | 1 | Data CRC error strobe from the link |
| ack_i | input | 1 | Packet ACK strobe (ends a read retry) |
| nack_i | input | 1 | Packet NACK strobe (ends a read retry) |
| rx_flush_o | output | 1 | RX buffer flush pulse |
| tx_flush_o | output | 1 | TX buffer flush pulse |
| busy_o | output | 1 | Busy toward the host |
| crc_irq_o | output | 1 | Sticky CRC-error interrupt flag |
| ctrl_o | output | 4 | Current control word |

## Verification
Every result appears exactly one cycle after the input edge that causes it. This covers:
- flush pulses from writes or from ACK/NACK;
- the enable clear and busy set from a CRC error;
- busy release from an enable write;
- setting and clearing of the CRC flag.

The bench drives inputs on the falling edge and holds them across one rising edge. A behavioural model updates on that rising edge, and every output is compared with the model at the next falling edge. Directed checks are sampled at that same falling edge, straight after the stimulus cycle. A second check one cycle later confirms that each pulse has ended.

// File: rtl/sdio_fc_pkg.sv
package sdio_fc_pkg;
  localparam int CTRL_W       = 4;
  localparam int CTRL_EN      = 0;
  localparam int CTRL_ARM     = 1;
  localparam int CTRL_AUTO_TX = 2;
  localparam int CTRL_HSYNC   = 3;
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'h7;

  localparam int FLUSH_RX_BIT = 0;
  localparam int FLUSH_TX_BIT = 1;
  localparam int NUM_BUF      = 2;
  localparam int CRC_CLR_BIT  = 12;

  typedef enum logic [1:0] {
    SEL_FLUSH = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_CLR   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/sdio_fc_ctrl_reg.sv
module sdio_fc_ctrl_reg
  import sdio_fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              crc_err_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q;

  // hardware clear of enable overrides a same-cycle firmware write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else begin
      if (wr_i) ctrl_q <= wdata_i;
      if (crc_err_i) ctrl_q[CTRL_EN] <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  AST_EN_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i |=> !ctrl_o[CTRL_EN]); // R3 R9

  AST_HSYNC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o[CTRL_HSYNC])); // R11
endmodule

// File: rtl/sdio_fc_crc_busy.sv
module sdio_fc_crc_busy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic crc_err_i,
  input  logic en_i,
  input  logic arm_i,
  input  logic en_wr_one_i,
  input  logic flag_clr_i,
  output logic busy_o,
  output logic flag_o
);
  logic busy_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (crc_err_i && en_i && arm_i) begin
      busy_q <= 1'b1;
    end else if (en_wr_one_i && !crc_err_i) begin
      busy_q <= 1'b0;
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (crc_err_i) begin
      flag_q <= 1'b1;
    end else if (flag_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign flag_o = flag_q;

  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(crc_err_i && en_i && arm_i)); // R4

  AST_BUSY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(en_wr_one_i && !crc_err_i)); // R5 R9

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_i |=> flag_o); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i)); // R10
endmodule

// File: rtl/sdio_fc_flush_gen.sv
module sdio_fc_flush_gen #(
  parameter int NBUF = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NBUF-1:0] fw_req_i,
  input  logic [NBUF-1:0] hw_req_i,
  output logic [NBUF-1:0] pulse_o
);
  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    logic pulse_q;
    // coincident requests merge into one pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= fw_req_i[i] | hw_req_i[i];
    end
    assign pulse_o[i] = pulse_q;
  end
endmodule

// File: rtl/sdio_flush_crc_ctrl.sv
module sdio_flush_crc_ctrl
  import sdio_fc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              crc_err_i,
  input  logic              ack_i,
  input  logic              nack_i,
  output logic              rx_flush_o,
  output logic              tx_flush_o,
  output logic              busy_o,
  output logic              crc_irq_o,
  output logic [3:0]        ctrl_o
);
  localparam int MIN_W = CRC_CLR_BIT + 1;

  if (DATA_W < MIN_W) begin : g_bad_width
    initial $error("DATA_W too small");
  end

  logic              wr_flush, wr_ctrl, wr_clr;
  logic [CTRL_W-1:0] ctrl;
  logic [NUM_BUF-1:0] fw_req, hw_req, pulses;
  logic              retry_done;
  logic              wdata_unused;

  assign wr_flush   = reg_wr_i && (reg_sel_i == SEL_FLUSH);
  assign wr_ctrl    = reg_wr_i && (reg_sel_i == SEL_CTRL);
  assign wr_clr     = reg_wr_i && (reg_sel_i == SEL_CLR);
  assign retry_done = ack_i | nack_i;
  assign wdata_unused = ^reg_wdata_i;

  always_comb begin
    fw_req = '0;
    hw_req = '0;
    fw_req[FLUSH_RX_BIT] = wr_flush && reg_wdata_i[FLUSH_RX_BIT];
    fw_req[FLUSH_TX_BIT] = wr_flush && reg_wdata_i[FLUSH_TX_BIT];
    hw_req[FLUSH_TX_BIT] = ctrl[CTRL_AUTO_TX] && retry_done;
  end

  sdio_fc_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctrl),
    .wdata_i   (reg_wdata_i[CTRL_W-1:0]),
    .crc_err_i (crc_err_i),
    .ctrl_o    (ctrl)
  );

  sdio_fc_crc_busy u_busy (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .crc_err_i   (crc_err_i),
    .en_i        (ctrl[CTRL_EN]),
    .arm_i       (ctrl[CTRL_ARM]),
    .en_wr_one_i (wr_ctrl && reg_wdata_i[CTRL_EN]),
    .flag_clr_i  (wr_clr && reg_wdata_i[CRC_CLR_BIT]),
    .busy_o      (busy_o),
    .flag_o      (crc_irq_o)
  );

  sdio_fc_flush_gen #(.NBUF(NUM_BUF)) u_flush (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fw_req_i (fw_req),
    .hw_req_i (hw_req),
    .pulse_o  (pulses)
  );

  assign rx_flush_o = pulses[FLUSH_RX_BIT];
  assign tx_flush_o = pulses[FLUSH_TX_BIT];
  assign ctrl_o     = ctrl;

  AST_RX_FLUSH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |-> $past(reg_wr_i && reg_sel_i == SEL_FLUSH && reg_wdata_i[0])); // R1

  AST_TX_AUTO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_done && ctrl_o[2]) |=> tx_flush_o); // R6

  AST_TX_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |-> $past((reg_wr_i && reg_sel_i == SEL_FLUSH && reg_wdata_i[1]) ||
                         (ctrl_o[2] && (ack_i || nack_i)))); // R7
endmodule

// File: tb/sdio_flush_crc_ctrl_test.sv
`timescale 1ns/1ps
module sdio_flush_crc_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr = 0;
  logic [1:0]  sel = 0;
  logic [15:0] wdata = 0;
  logic        crc = 0, ack = 0, nack = 0;
  logic        rx_f, tx_f, busy, irq;
  logic [3:0]  ctrl;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_ctrl, m_busy, m_flag, m_rx, m_tx;

  always #2 clk = ~clk;

  sdio_flush_crc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .crc_err_i(crc), .ack_i(ack), .nack_i(nack),
    .rx_flush_o(rx_f), .tx_flush_o(tx_f), .busy_o(busy),
    .crc_irq_o(irq), .ctrl_o(ctrl)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 7; m_busy = 0; m_flag = 0; m_rx = 0; m_tx = 0;
    end else begin
      int en, arm, auto_tx, n_ctrl;
      bit fl, cw, cl;
      en = m_ctrl % 2; arm = (m_ctrl / 2) % 2; auto_tx = (m_ctrl / 4) % 2;
      fl = wr && sel == 0; cw = wr && sel == 1; cl = wr && sel == 2;
      m_rx = (fl && wdata[0]) ? 1 : 0;
      m_tx = ((fl && wdata[1]) || (auto_tx == 1 && (ack || nack))) ? 1 : 0;
      n_ctrl = cw ? int'(wdata[3:0]) : m_ctrl;
      if (crc) n_ctrl = n_ctrl - (n_ctrl % 2);
      if (crc && en == 1 && arm == 1) m_busy = 1;
      else if (cw && wdata[0] && !crc) m_busy = 0;
      if (crc) m_flag = 1;
      else if (cl && wdata[12]) m_flag = 0;
      m_ctrl = n_ctrl;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 rx_flush model", rx_f, m_rx);
      chk("R6 tx_flush model", tx_f, m_tx);
      chk("R4 busy model", busy, m_busy);
      chk("R10 crc flag model", irq, m_flag);
      chk("R3 ctrl model", ctrl, m_ctrl);
    end
  end

  // one stimulus cycle; returns at the falling edge after the rising edge
  task automatic cyc(input bit w, input int s, input int d,
                     input bit c, input bit a, input bit n);
    wr = w; sel = s[1:0]; wdata = d[15:0]; crc = c; ack = a; nack = n;
    @(negedge clk);
    wr = 0; sel = 0; wdata = 0; crc = 0; ack = 0; nack = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 ctrl reset", ctrl, 7);
    chk("R2 busy reset", busy, 0);
    chk("R2 flag reset", irq, 0);
    chk("R2 flush reset", {rx_f, tx_f}, 0);

    cyc(1, 0, 1, 0, 0, 0); chk("R1 rx pulse", rx_f, 1); chk("R1 no tx", tx_f, 0);
    idle();                chk("R1 rx ends", rx_f, 0);
    cyc(1, 0, 2, 0, 0, 0); chk("R1 tx pulse", tx_f, 1); chk("R1 no rx", rx_f, 0);
    cyc(1, 0, 3, 0, 0, 0); chk("R1 both", {rx_f, tx_f}, 3);
    idle();

    cyc(0, 0, 0, 0, 1, 0); chk("R6 ack flush", tx_f, 1);
    idle();                chk("R6 ack ends", tx_f, 0);
    cyc(0, 0, 0, 0, 0, 1); chk("R6 nack flush", tx_f, 1);
    idle();
    cyc(1, 0, 2, 0, 1, 0); chk("R8 merged pulse", tx_f, 1);
    idle();                chk("R8 single cycle", tx_f, 0);

    cyc(1, 1, 3, 0, 0, 0); chk("R7 ctrl auto off", ctrl, 3);
    cyc(0, 0, 0, 0, 1, 0); chk("R7 ack no flush", tx_f, 0);
    cyc(0, 0, 0, 0, 0, 1); chk("R7 nack no flush", tx_f, 0);
    cyc(1, 0, 2, 0, 0, 0); chk("R7 manual flush", tx_f, 1);
    idle();

    cyc(1, 1, 11, 0, 0, 0); chk("R11 hsync stored", ctrl, 11);
    cyc(0, 0, 0, 0, 1, 0);  chk("R11 no auto effect", tx_f, 0);

    cyc(0, 0, 0, 1, 0, 0);
    chk("R3 en cleared", ctrl, 10);
    chk("R4 busy set", busy, 1);
    chk("R10 flag set", irq, 1);
    repeat (3) idle();
    chk("R5 busy held", busy, 1);
    chk("R10 flag held", irq, 1);
    cyc(1, 2, 16'h0FFF, 0, 0, 0); chk("R10 wrong bit no clear", irq, 1);
    cyc(1, 2, 16'h1000, 0, 0, 0); chk("R10 flag cleared", irq, 0);
    chk("R5 busy after clear", busy, 1);
    cyc(1, 1, 10, 0, 0, 0); chk("R5 en=0 write keeps busy", busy, 1);
    cyc(1, 1, 11, 0, 0, 0); chk("R5 busy released", busy, 0);

    cyc(1, 1, 3, 1, 0, 0);
    chk("R9 hw clear wins", ctrl, 2);
    chk("R9 busy set", busy, 1);
    cyc(1, 1, 11, 0, 0, 0); chk("R5 release again", busy, 0);
    cyc(1, 1, 11, 1, 0, 0);
    chk("R9 busy not released", busy, 1);
    chk("R9 ctrl", ctrl, 10);
    cyc(1, 1, 9, 0, 0, 0); chk("R5 release", busy, 0);

    cyc(0, 0, 0, 1, 0, 0); chk("R4 no busy unarmed", busy, 0); chk("R3 en clr", ctrl, 8);
    cyc(1, 1, 2, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 0); chk("R4 no busy disabled", busy, 0);
    cyc(1, 2, 16'h1000, 1, 0, 0); chk("R10 set beats clear", irq, 1);
    cyc(1, 2, 16'h1000, 0, 0, 0); chk("R10 cleared", irq, 0);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      cyc(r[0] & r[1], r[3:2] % 3, (r[4] ? 16'h1000 : 16'h0) | (r[11:8] | 16'(r[5])),
          r[12] & r[13] & r[14], r[15] & r[16], r[17] & r[18]);
    end

    finish_run();
  end
endmodule